// File: doc/BRIEF.md
# LIN Response Checksum Unit

This block produces or validates the checksum byte that closes a LIN response. A single-cycle start pulse opens a frame and picks, for that frame, the summing rule (classic: data bytes only; enhanced: the protected identifier byte is added as well) and the direction. In transmit direction the checksum is an output: the host streams the data bytes, flags the final one, and reads back the byte to append. In receive direction the host streams the received data bytes and then the received checksum byte, marked as last, and the block reports whether the frame's checksum is good.

The sum is an 8-bit addition in which any carry out of the top bit is folded back into the least significant bit. The checksum is the bitwise inverse of the final sum. Validation compares the received byte with that inverse, bit for bit. A check that instead adds the received byte to the sum and tests for all ones wrongly passes a frame whose sum is 0xFF and whose received byte is 0xFF. The exact comparison used here rejects that frame. A frame with no data bytes, or with more than the allowed number, is reported as a length error and yields no checksum result.

Top module: `lin_cksum_unit`

## Requirements
- R1: After reset, `cksum_o`, `done_o`, `cksum_err_o` and `len_err_o` are all 0, and the unit is idle.
- R2: A `start_i` pulse clears any previous frame state and result. With `enh_i`=1 the PID byte on `pid_i` is the initial sum. With `enh_i`=0 the initial sum is 0x00.
- R3: Each accepted data byte is added to the sum with 8-bit addition, and a carry out of bit 7 is added back into bit 0.
- R4: With `xmit_i`=1 at start, `last_i` marks the final data byte, which is included in the sum. In the clock after that byte is sampled, `done_o` is 1 and `cksum_o` equals the inverted sum.
- R5: With `xmit_i`=0 at start, the byte sampled with `last_i`=1 is the received checksum and is not summed. In the clock after it, `done_o` is 1, `cksum_o` equals the inverted sum, and `cksum_err_o` is 1 exactly when the received byte differs from it. This includes a sum of 0xFF with a received byte of 0xFF, which must report an error, and a received 0x00 for that sum, which must pass.
- R6: In receive direction, a last byte that arrives before any data byte ends the frame with `len_err_o`=1, `cksum_err_o`=0 and `cksum_o`=0x00.
- R7: A data byte beyond MAX_BYTES (default 8) ends the frame with `len_err_o`=1, `cksum_err_o`=0 and `cksum_o`=0x00, in either direction.
- R8: `done_o` is high for exactly one clock per frame. `cksum_o`, `cksum_err_o` and `len_err_o` hold their values until the next start.
- R9: Bytes presented while no frame is open are ignored. A byte presented in the same clock as `start_i` is ignored, and the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a new frame |
| enh_i | input | 1 | Sampled at start: 1 selects the enhanced sum that includes the PID |
| xmit_i | input | 1 | Sampled at start: 1 selects transmit, 0 selects receive |
| pid_i | input | 8 | PID byte, sampled at start |
| byte_i | input | 8 | Data byte, or in receive direction the checksum byte |
| byte_vld_i | input | 1 | `byte_i` is valid this clock |
| last_i | input | 1 | Marks the final byte of the frame, valid together with `byte_vld_i` |
| cksum_o | output | 8 | Computed checksum; 0x00 when there is a length error |
| done_o | output | 1 | One-clock pulse when the frame completes |
| cksum_err_o | output | 1 | Received checksum mismatch |
| len_err_o | output | 1 | Data byte count outside 1..MAX_BYTES |

## Verification
Every result is registered once. `done_o`, `cksum_o` and both error flags are due in the clock that follows the edge that samples the last byte. A start therefore clears all four at the following edge. The bench drives inputs on falling edges and samples at the next falling edge after the closing byte, where it expects `done_o` high. It samples once more a clock later, where `done_o` must be low and the result must be unchanged. Reference sums come from integer arithmetic in the bench, over swept lengths, modes, directions and all 256 single-byte values.

// File: rtl/lin_cksum_pkg.sv
package lin_cksum_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // end-around-carry byte addition
  function automatic logic [BYTE_W-1:0] eac_add(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, wide[BYTE_W]};
  endfunction
endpackage

// File: rtl/lin_cksum_acc.sv
module lin_cksum_acc
  import lin_cksum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              enh,
  input  logic [BYTE_W-1:0] pid,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] sum,
  output logic [BYTE_W-1:0] sum_plus
);
  assign sum_plus = eac_add(sum, din);

  always_ff @(posedge clk) begin
    if (rst)         sum <= '0;
    else if (clr)    sum <= enh ? pid : '0;
    else if (add_en) sum <= sum_plus;
  end

  // R2: seed after a start
  p_seed_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sum == ($past(enh) ? $past(pid) : '0)));

  // R3: sum only moves on an accepted byte or a start
  p_sum_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !add_en) |=> $stable(sum));
endmodule

// File: rtl/lin_cksum_len.sv
module lin_cksum_len #(
  parameter int MAX_BYTES = 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (cnt_en) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R7: counter never passes the limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  // R7: overflow only from a full counter
  p_ovf_from_full_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(full));
endmodule

// File: rtl/lin_cksum_unit.sv
module lin_cksum_unit
  import lin_cksum_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              enh_i,
  input  logic              xmit_i,
  input  logic [BYTE_W-1:0] pid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              last_i,
  output logic [BYTE_W-1:0] cksum_o,
  output logic              done_o,
  output logic              cksum_err_o,
  output logic              len_err_o
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic              busy_q;
  dir_e              dir_q;
  logic              take, fin, data_take;
  logic [BYTE_W-1:0] sum, sum_plus, final_inv;
  logic [CNT_W-1:0]  cnt;
  logic              empty, full, ovf, bad_len;

  assign take      = byte_vld_i && busy_q && !start_i;
  assign fin       = take && last_i;
  assign data_take = take && ((dir_q == DIR_TX) || !last_i);

  lin_cksum_acc u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_i),
    .enh     (enh_i),
    .pid     (pid_i),
    .add_en  (data_take),
    .din     (byte_i),
    .sum     (sum),
    .sum_plus(sum_plus)
  );

  lin_cksum_len #(.MAX_BYTES(MAX_BYTES)) u_len (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_i),
    .cnt_en(data_take),
    .cnt   (cnt),
    .empty (empty),
    .full  (full),
    .ovf   (ovf)
  );

  always_comb begin
    if (dir_q == DIR_TX) begin
      final_inv = ~sum_plus;
      bad_len   = ovf || full;
    end else begin
      final_inv = ~sum;
      bad_len   = ovf || empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      dir_q       <= DIR_RX;
      cksum_o     <= '0;
      done_o      <= 1'b0;
      cksum_err_o <= 1'b0;
      len_err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q      <= 1'b1;
        dir_q       <= dir_e'(xmit_i);
        cksum_o     <= '0;
        cksum_err_o <= 1'b0;
        len_err_o   <= 1'b0;
      end else if (fin) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
        if (bad_len) begin
          cksum_o     <= '0;
          cksum_err_o <= 1'b0;
          len_err_o   <= 1'b1;
        end else begin
          cksum_o     <= final_inv;
          cksum_err_o <= (dir_q == DIR_RX) && (byte_i != final_inv);
          len_err_o   <= 1'b0;
        end
      end
    end
  end

  // R8: single-clock completion pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: result moves only on a start or a completion
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cksum_o) |-> ($past(start_i) || done_o));

  // R2: start clears every result
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!done_o && !cksum_err_o && !len_err_o && cksum_o == '0));

  // R6: a length error suppresses the checksum verdict
  p_len_masks_r6: assert property (@(posedge clk) disable iff (rst)
    len_err_o |-> (!cksum_err_o && cksum_o == '0));

  // R9: nothing completes while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_q || start_i) |=> !done_o);
endmodule

// File: tb/test_lin_cksum_unit.sv
module test_lin_cksum_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 0, enh_i = 0, xmit_i = 0, byte_vld_i = 0, last_i = 0;
  logic [7:0] pid_i = 0, byte_i = 0;
  logic [7:0] cksum_o;
  logic       done_o, cksum_err_o, len_err_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] arr [0:15];

  always #2 clk = ~clk;

  lin_cksum_unit i_lin_cksum_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .enh_i(enh_i), .xmit_i(xmit_i),
    .pid_i(pid_i), .byte_i(byte_i), .byte_vld_i(byte_vld_i), .last_i(last_i),
    .cksum_o(cksum_o), .done_o(done_o), .cksum_err_o(cksum_err_o),
    .len_err_o(len_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_sum(input bit enh, input int pid, input int n);
    int s = enh ? pid : 0;
    for (int i = 0; i < n; i++) begin
      s = s + arr[i];
      if (s > 255) s = s - 255;
    end
    return s;
  endfunction

  // n data bytes from arr; in receive direction rx is the checksum byte
  task automatic frame(input bit tx, input bit enh, input logic [7:0] pid,
                       input int n, input logic [7:0] rx, input string req);
    int s;
    bit lerr;
    int ek;
    @(negedge clk);
    start_i = 1; enh_i = enh; xmit_i = tx; pid_i = pid;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1; byte_i = arr[i]; last_i = tx && (i == n - 1);
      @(negedge clk);
    end
    if (!tx) begin
      byte_vld_i = 1; byte_i = rx; last_i = 1;
      @(negedge clk);
    end
    byte_vld_i = 0; last_i = 0;
    s    = ref_sum(enh, pid, (n > 8) ? 8 : n);
    lerr = (n == 0) || (n > 8);
    ek   = lerr ? 0 : (~s & 8'hFF);
    chk({req, " done"}, done_o, 1);
    chk({req, " len"}, len_err_o, lerr);
    chk({req, " cksum"}, cksum_o, ek);
    chk({req, " err"}, cksum_err_o, (!tx && !lerr && rx != ek[7:0]) ? 1 : 0);
    @(negedge clk);
    chk("R8 done single", done_o, 0);
    chk("R8 hold", cksum_o, ek);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] ok;
    repeat (3) @(negedge clk);
    chk("R1 cksum", cksum_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", cksum_err_o, 0);
    chk("R1 len", len_err_o, 0);
    rst = 0;

    // example frame, enhanced; sum 0xFF with no end-around carry
    arr[0] = 8'h2C; arr[1] = 8'h3A; arr[2] = 8'h93;
    for (int i = 3; i < 8; i++) arr[i] = 8'h00;
    frame(0, 1, 8'h06, 8, 8'h00, "R5 pass 00");
    frame(0, 1, 8'h06, 8, 8'hFF, "R5 reject FF");
    frame(0, 1, 8'h06, 8, 8'h01, "R5 reject 01");
    frame(1, 1, 8'h06, 8, 8'h00, "R4 tx example");

    // R3: carries folded back
    arr[0] = 8'hFF; arr[1] = 8'hFF; arr[2] = 8'h80; arr[3] = 8'h81;
    frame(1, 0, 8'h00, 4, 8'h00, "R3 carry tx");
    // R2: enhanced seed is the PID
    arr[0] = 8'h00;
    frame(1, 1, 8'hA5, 1, 8'h00, "R2 pid seed");
    frame(1, 0, 8'hA5, 1, 8'h00, "R2 classic seed");

    // sweep lengths, modes, directions
    seed = 7;
    for (int n = 1; n <= 8; n++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 6; r++) begin
          for (int i = 0; i < 8; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            arr[i] = seed[23:16];
          end
          ok = ~ref_sum(m[0], seed[7:0], n);
          frame(m[1], m[0], seed[7:0], n, (r[0]) ? ok : ok ^ seed[15:8],
                m[1] ? "R4 sweep" : "R5 sweep");
        end

    // all single bytes, classic receive
    for (int v = 0; v < 256; v++) begin
      arr[0] = v[7:0];
      frame(0, 0, 8'h00, 1, ~v[7:0], "R5 single good");
      frame(0, 0, 8'h00, 1, v[7:0], "R5 single bad");
    end

    // length errors
    frame(0, 1, 8'h33, 0, 8'h00, "R6 empty");
    for (int i = 0; i < 9; i++) arr[i] = 8'h11;
    frame(0, 0, 8'h00, 9, 8'h00, "R7 ninth rx");
    frame(1, 1, 8'h22, 9, 8'h00, "R7 ninth tx");

    // R9: idle bytes ignored
    arr[0] = 8'h40;
    frame(1, 0, 8'h00, 1, 8'h00, "R9 setup");
    byte_vld_i = 1; last_i = 1; byte_i = 8'h99;
    @(negedge clk);
    @(negedge clk);
    byte_vld_i = 0; last_i = 0;
    @(negedge clk);
    chk("R9 idle done", done_o, 0);
    chk("R9 idle cksum", cksum_o, 8'hBF);

    // R9: byte with start ignored
    start_i = 1; enh_i = 0; xmit_i = 1; byte_vld_i = 1; byte_i = 8'h77; last_i = 1;
    @(negedge clk);
    start_i = 0; byte_i = 8'h10;
    @(negedge clk);
    byte_vld_i = 0; last_i = 0;
    chk("R9 start wins done", done_o, 1);
    chk("R9 start wins cksum", cksum_o, 8'hEF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule